// File: doc/BRIEF.md
# Unpacked Float to Single-Precision Packer

This block turns an unpacked floating-point value into a 32-bit IEEE-754 single-precision word and reports the exceptions raised on the way. The value arrives as a sign, a class code, a signed unbiased exponent, a wide mantissa, a sticky bit and a rounding mode. For an ordinary number the mantissa holds the leading one in its top bit and extra guard and round bits below the 24 bits that are kept. The block adds the bias to the exponent and shifts subnormal results right by the exponent deficit. It rounds in the requested mode and moves a rounding carry into the exponent. Results too large for the format saturate according to the mode and the sign.

The block sits at the end of a floating-point datapath, after the arithmetic has produced a wide result. It has one register stage. Each accepted input yields one result word, one flag vector and a valid strobe on the next clock edge.

Top module: `sp_packer`

## Requirements
- R1: A result appears exactly one clock after `in_valid` is sampled high, with `out_valid` high for that one cycle. After reset `out_valid`, `out_word` and `out_flags` are all zero. The flag vector is {operr, ovfl, unfl, inex}: operr is bit 3, ovfl bit 2, unfl bit 1 and inex bit 0.
- R2: A zero input (class 0) yields the sign in bit 31 with every other bit zero, and no flags.
- R3: An infinity input (class 2) yields the sign, exponent field 0xFF and a zero fraction, and no flags.
- R4: A NaN input (class 3) yields the sign, exponent field 0xFF, and as the fraction the 23 mantissa bits just below the top bit (bits MANT_W-2 down to MANT_W-24). It raises no flags. Only a NaN input produces exponent 0xFF with a nonzero fraction.
- R5: For a number (class 1), the biased exponent is the input exponent plus 127. When that sum is at least 1, the fraction is formed from the 23 mantissa bits below the leading one. An exact result raises no flag.
- R6: The rounding mode is coded 0 = to nearest with ties to even, 1 = toward zero, 2 = toward minus infinity, 3 = toward plus infinity. The guard bit sits just below the 24 kept bits and the round bit below it. The sticky bit is the OR of all lower bits and `in_sticky`. When guard, round or sticky is set, inex is raised.
- R7: When rounding carries the mantissa up to 2.0 on the normal path, the exponent field rises by one and the fraction is zero.
- R8: A biased exponent of 0 or below takes the subnormal path. There unfl is always raised, the mantissa is shifted right by (1 - biased exponent) into a zero exponent field, and the result is then rounded.
- R9: A subnormal that rounds up into the smallest normal yields exponent field 1 and fraction 0.
- R10: A final biased exponent of 255 or more raises operr, ovfl and inex together.
- R11: On overflow the result is infinity (exponent 0xFF, fraction 0) in nearest mode, for positive values in toward-plus-infinity mode and for negative values in toward-minus-infinity mode. In every other case it is exponent 0xFE with an all-ones fraction, with the sign kept.
- R12: While `in_valid` is low the inputs have no effect: `out_valid` stays low and `out_word` and `out_flags` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input value is present this cycle |
| in_sign | input | 1 | Sign of the value |
| in_class | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_mant | input | MANT_W | Mantissa, leading one at the top bit |
| in_sticky | input | 1 | OR of bits already shifted out below the mantissa |
| in_mode | input | 2 | Rounding mode |
| out_valid | output | 1 | Result strobe |
| out_word | output | 32 | Packed single-precision word |
| out_flags | output | 4 | {operr, ovfl, unfl, inex} |

## Verification
The assertions check properties that hold on every cycle. They cover the one-cycle valid timing and the hold while idle, the zero encoding, and that a NaN pattern comes only from a NaN input. They also check that ovfl always comes with operr and inex, that unfl appears only with a tiny exponent field, and that toward-zero rounding never produces infinity from a number. Only the bench scenarios show the exact values. These are tie-to-even against odd and even kept bits, carries into the exponent, the subnormal shift amounts, the step from subnormal to smallest normal, and the overflow choice for each mode and sign. A scoreboard compares every result against a model written from the requirements, for both directed and random values.

// File: rtl/sp_pack_pkg.sv
package sp_pack_pkg;

   localparam int FRAC_W = 23;
   localparam int EFLD_W = 8;
   localparam int BIAS   = 127;
   localparam int EF_TOP = 255;

   typedef enum logic [1:0] {
      CLS_ZERO = 2'd0,
      CLS_NUM  = 2'd1,
      CLS_INF  = 2'd2,
      CLS_NAN  = 2'd3
   } num_class_e;

   typedef enum logic [1:0] {
      RND_NEAR = 2'd0,
      RND_ZERO = 2'd1,
      RND_DOWN = 2'd2,
      RND_UP   = 2'd3
   } rnd_mode_e;

   typedef struct packed {
      logic operr;
      logic ovfl;
      logic unfl;
      logic inex;
   } pack_flags_t;

endpackage

// File: rtl/sp_align.sv
module sp_align
   import sp_pack_pkg::*;
#(
   parameter int MANT_W = 32,
   parameter int EXP_W  = 12
) (
   input  logic signed [EXP_W-1:0]  exp_in,
   input  logic        [MANT_W-1:0] mant_in,
   input  logic                     sticky_in,
   output logic signed [EXP_W+1:0]  ebiased,
   output logic                     subnorm,
   output logic        [FRAC_W:0]   kept,
   output logic                     guard_b,
   output logic                     round_b,
   output logic                     sticky_b
);
   localparam int SH_MAX = FRAC_W + 4;
   localparam int SH_W   = $clog2(SH_MAX + 1);
   localparam int XW     = MANT_W + SH_MAX;
   localparam int EW     = EXP_W + 2;

   logic signed [EW-1:0] deficit;
   logic        [SH_W-1:0] shamt;
   logic        [XW-1:0]   wide;

   always_comb begin
      ebiased = EW'(exp_in) + EW'(BIAS);
      subnorm = (ebiased <= 0);
      deficit = EW'(1) - ebiased;
      if (!subnorm)
         shamt = '0;
      else if (deficit > EW'(SH_MAX))
         shamt = SH_W'(SH_MAX);
      else
         shamt = deficit[SH_W-1:0];
      wide     = {mant_in, {SH_MAX{1'b0}}} >> shamt;
      kept     = wide[XW-1 -: FRAC_W+1];
      guard_b  = wide[XW-FRAC_W-2];
      round_b  = wide[XW-FRAC_W-3];
      sticky_b = (|wide[XW-FRAC_W-4:0]) | sticky_in;
   end
endmodule

// File: rtl/sp_round.sv
module sp_round
   import sp_pack_pkg::*;
(
   input  logic              sign_in,
   input  logic [1:0]        mode_in,
   input  logic [FRAC_W:0]   kept,
   input  logic              guard_b,
   input  logic              round_b,
   input  logic              sticky_b,
   output logic [FRAC_W+1:0] sum,
   output logic              inexact
);
   logic bump;

   always_comb begin
      inexact = guard_b | round_b | sticky_b;
      unique case (rnd_mode_e'(mode_in))
         RND_NEAR: bump = guard_b & (round_b | sticky_b | kept[0]);
         RND_ZERO: bump = 1'b0;
         RND_DOWN: bump = inexact & sign_in;
         RND_UP:   bump = inexact & ~sign_in;
         default:  bump = 1'b0;
      endcase
      sum = {1'b0, kept} + (FRAC_W+2)'(bump);
   end
endmodule

// File: rtl/sp_ovf_sat.sv
module sp_ovf_sat
   import sp_pack_pkg::*;
(
   input  logic        sign_in,
   input  logic [1:0]  mode_in,
   output logic [30:0] sat_mag
);
   logic to_inf;

   always_comb begin
      unique case (rnd_mode_e'(mode_in))
         RND_NEAR: to_inf = 1'b1;
         RND_ZERO: to_inf = 1'b0;
         RND_DOWN: to_inf = sign_in;
         RND_UP:   to_inf = ~sign_in;
         default:  to_inf = 1'b1;
      endcase
      sat_mag = to_inf ? {8'hFF, {FRAC_W{1'b0}}} : {8'hFE, {FRAC_W{1'b1}}};
   end
endmodule

// File: rtl/sp_packer.sv
module sp_packer
   import sp_pack_pkg::*;
#(
   parameter int MANT_W = 32,
   parameter int EXP_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sign,
   input  logic [1:0]        in_class,
   input  logic [EXP_W-1:0]  in_exp,
   input  logic [MANT_W-1:0] in_mant,
   input  logic              in_sticky,
   input  logic [1:0]        in_mode,
   output logic              out_valid,
   output logic [31:0]       out_word,
   output logic [3:0]        out_flags
);
   localparam int EW = EXP_W + 2;

   generate
      if (MANT_W < FRAC_W + 3) begin : g_bad_mant
         $error("sp_packer: MANT_W must hold 24 kept bits plus guard and round");
      end
      if (EXP_W < 10) begin : g_bad_exp
         $error("sp_packer: EXP_W too narrow for the exponent range");
      end
   endgenerate

   logic signed [EW-1:0]  ebiased;
   logic                  subnorm;
   logic [FRAC_W:0]       kept;
   logic                  g_b, r_b, s_b;
   logic [FRAC_W+1:0]     sum;
   logic                  inexact;
   logic [30:0]           sat_mag;
   logic signed [EW-1:0]  efinal;
   logic [31:0]           word_d;
   pack_flags_t           flags_d;

   sp_align #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_align (
      .exp_in   ($signed(in_exp)),
      .mant_in  (in_mant),
      .sticky_in(in_sticky),
      .ebiased  (ebiased),
      .subnorm  (subnorm),
      .kept     (kept),
      .guard_b  (g_b),
      .round_b  (r_b),
      .sticky_b (s_b)
   );

   sp_round u_round (
      .sign_in (in_sign),
      .mode_in (in_mode),
      .kept    (kept),
      .guard_b (g_b),
      .round_b (r_b),
      .sticky_b(s_b),
      .sum     (sum),
      .inexact (inexact)
   );

   sp_ovf_sat u_sat (
      .sign_in(in_sign),
      .mode_in(in_mode),
      .sat_mag(sat_mag)
   );

   always_comb begin
      efinal  = ebiased + EW'(sum[FRAC_W+1]);
      word_d  = {in_sign, 31'd0};
      flags_d = '0;
      unique case (num_class_e'(in_class))
         CLS_ZERO: word_d = {in_sign, 31'd0};
         CLS_INF:  word_d = {in_sign, 8'hFF, {FRAC_W{1'b0}}};
         CLS_NAN:  word_d = {in_sign, 8'hFF, in_mant[MANT_W-2 -: FRAC_W]};
         CLS_NUM: begin
            flags_d.inex = inexact;
            if (subnorm) begin
               flags_d.unfl = 1'b1;
               if (sum[FRAC_W])
                  word_d = {in_sign, 8'd1, {FRAC_W{1'b0}}};
               else
                  word_d = {in_sign, 8'd0, sum[FRAC_W-1:0]};
            end else if (efinal >= EW'(EF_TOP)) begin
               flags_d.operr = 1'b1;
               flags_d.ovfl  = 1'b1;
               flags_d.inex  = 1'b1;
               word_d        = {in_sign, sat_mag};
            end else begin
               word_d = {in_sign, efinal[EFLD_W-1:0], sum[FRAC_W-1:0]};
            end
         end
         default: word_d = {in_sign, 31'd0};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
         out_flags <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_word  <= word_d;
            out_flags <= flags_d;
         end
      end
   end
endmodule

// File: rtl/sp_pack_chk.sv
module sp_pack_chk #(
   parameter int MANT_W = 32,
   parameter int EXP_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_sign,
   input logic [1:0]        in_class,
   input logic [1:0]        in_mode,
   input logic              out_valid,
   input logic [31:0]       out_word,
   input logic [3:0]        out_flags
);
   assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_word) && $stable(out_flags)));

   assert_zero_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class == 2'd0) |=>
         (out_word == {$past(in_sign), 31'd0} && out_flags == 4'd0));

   assert_nan_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_word[30:23] == 8'hFF && out_word[22:0] != 23'd0) |->
         $past(in_class) == 2'd3);

   assert_ovfl_companions_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_flags[2]) |-> (out_flags[3] && out_flags[0]));

   assert_unfl_tiny_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_flags[1]) |-> (out_word[30:24] == 7'd0));

   assert_chop_finite_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class == 2'd1 && in_mode == 2'd1) |=> (out_word[30:23] != 8'hFF));
endmodule

bind sp_packer sp_pack_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_sign  (in_sign),
   .in_class (in_class),
   .in_mode  (in_mode),
   .out_valid(out_valid),
   .out_word (out_word),
   .out_flags(out_flags)
);

// File: tb/sp_packer_test.sv
module sp_packer_test;
   localparam int MW = 32;
   localparam int EW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_sign = 1'b0;
   logic [1:0]    in_class = 2'd0;
   logic [EW-1:0] in_exp = '0;
   logic [MW-1:0] in_mant = '0;
   logic          in_sticky = 1'b0;
   logic [1:0]    in_mode = 2'd0;
   logic          out_valid;
   logic [31:0]   out_word;
   logic [3:0]    out_flags;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_w_q[$];
   logic [3:0]  exp_f_q[$];
   string       tag_q[$];
   logic [31:0] last_word = '0;
   logic [3:0]  last_flags = '0;

   always #4 clk = ~clk;

   sp_packer #(.MANT_W(MW), .EXP_W(EW)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
      .in_class(in_class), .in_exp(in_exp), .in_mant(in_mant),
      .in_sticky(in_sticky), .in_mode(in_mode), .out_valid(out_valid),
      .out_word(out_word), .out_flags(out_flags)
   );

   // Model from the requirements: returns {flags, word}
   function automatic logic [35:0] model(input logic sg, input logic [1:0] cl,
                                         input int e, input logic [31:0] m,
                                         input logic stk, input logic [1:0] md);
      int eb, sh;
      logic [71:0] v;
      logic [23:0] k;
      logic g, r, s, inx, up, inf_sel;
      logic [24:0] sm;
      if (cl == 2'd0) return {4'd0, sg, 31'd0};
      if (cl == 2'd2) return {4'd0, sg, 8'hFF, 23'd0};
      if (cl == 2'd3) return {4'd0, sg, 8'hFF, m[30:8]};
      eb = e + 127;
      sh = (eb <= 0) ? (1 - eb) : 0;
      if (sh > 40) sh = 40;
      v = {m, 40'd0} >> sh;
      k = v[71:48]; g = v[47]; r = v[46]; s = (|v[45:0]) | stk;
      inx = g | r | s;
      case (md)
         2'd0: up = g & (r | s | k[0]);
         2'd1: up = 1'b0;
         2'd2: up = inx & sg;
         default: up = inx & ~sg;
      endcase
      sm = {1'b0, k} + {24'd0, up};
      if (eb <= 0) begin
         if (sm[23]) return {3'b001, inx, sg, 8'd1, 23'd0};
         return {3'b001, inx, sg, 8'd0, sm[22:0]};
      end
      eb = eb + int'(sm[24]);
      if (eb >= 255) begin
         inf_sel = (md == 2'd0) || (md == 2'd2 && sg) || (md == 2'd3 && !sg);
         if (inf_sel) return {4'b1101, sg, 8'hFF, 23'd0};
         return {4'b1101, sg, 8'hFE, 23'h7FFFFF};
      end
      return {3'b000, inx, sg, 8'(eb), sm[22:0]};
   endfunction

   task automatic send(input logic sg, input logic [1:0] cl, input int e,
                       input logic [31:0] m, input logic stk, input logic [1:0] md,
                       input string tag);
      logic [35:0] x;
      @(negedge clk);
      in_valid = 1'b1; in_sign = sg; in_class = cl; in_exp = EW'(e);
      in_mant = m; in_sticky = stk; in_mode = md;
      x = model(sg, cl, e, m, stk, md);
      exp_w_q.push_back(x[31:0]);
      exp_f_q.push_back(x[35:32]);
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // Monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && out_valid) begin
            checks++;
            if (exp_w_q.size() == 0) begin
               errors++;
               $display("FAIL R1: unexpected result word %h flags %b, expected none",
                        out_word, out_flags);
            end else begin
               logic [31:0] ew;
               logic [3:0]  ef;
               string       t;
               ew = exp_w_q.pop_front();
               ef = exp_f_q.pop_front();
               t  = tag_q.pop_front();
               if (out_word !== ew || out_flags !== ef) begin
                  errors++;
                  $display("FAIL %s: word %h flags %b, expected word %h flags %b",
                           t, out_word, out_flags, ew, ef);
               end
            end
            last_word  = out_word;
            last_flags = out_flags;
         end
      end
   end

   // Watchdog
   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_word !== 32'd0 || out_flags !== 4'd0) begin
         errors++;
         $display("FAIL R1: reset state %b %h %b, expected 0 0 0",
                  out_valid, out_word, out_flags);
      end
      rst_n = 1'b1;
      idle(2);

      // R5 exact normals
      send(0, 1, 0,    32'h8000_0000, 0, 0, "R5 one");
      send(1, 1, 1,    32'hC000_0000, 0, 0, "R5 neg three");
      send(0, 1, 127,  32'hFFFF_FF00, 0, 1, "R5 max normal");
      send(0, 1, -126, 32'h8000_0000, 0, 0, "R5 min normal");
      // R2 R3 R4 specials
      send(1, 0, 5,    32'h1234_5678, 1, 0, "R2 neg zero");
      send(0, 3, 0,    32'hC000_1234, 0, 0, "R4 nan");
      send(1, 2, 0,    32'hFFFF_FFFF, 1, 3, "R3 neg inf");
      // R6 ties and modes
      send(0, 1, 0, 32'h8000_0080, 0, 0, "R6 tie even stays");
      send(0, 1, 0, 32'h8000_0180, 0, 0, "R6 tie odd rounds");
      send(0, 1, 0, 32'h8000_0080, 1, 0, "R6 sticky breaks tie");
      send(0, 1, 0, 32'h8000_0000, 1, 1, "R6 sticky only inexact");
      send(1, 1, 0, 32'h8000_0001, 0, 2, "R6 down negative");
      send(0, 1, 0, 32'h8000_0001, 0, 2, "R6 down positive");
      send(0, 1, 0, 32'h8000_0001, 0, 3, "R6 up positive");
      // R7 carry into exponent
      send(0, 1, 3, 32'hFFFF_FF80, 0, 0, "R7 carry");
      // R8 R9 subnormals
      send(0, 1, -127,  32'h8000_0000, 0, 0, "R8 eb zero");
      send(1, 1, -130,  32'hA000_0000, 0, 0, "R8 eb minus three");
      send(0, 1, -149,  32'h8000_0000, 0, 0, "R8 min subnormal");
      send(0, 1, -150,  32'h8000_0000, 0, 0, "R8 half min tie");
      send(0, 1, -150,  32'h8000_0001, 0, 0, "R8 above half min");
      send(0, 1, -1000, 32'h8000_0000, 0, 3, "R8 deep underflow");
      send(0, 1, -127,  32'hFFFF_FF00, 0, 0, "R9 to min normal");
      // R10 R11 overflow per mode and sign
      for (int md = 0; md < 4; md++) begin
         send(0, 1, 128, 32'h8000_0000, 0, 2'(md), "R11 pos overflow");
         send(1, 1, 128, 32'h8000_0000, 0, 2'(md), "R11 neg overflow");
      end
      send(0, 1, 127, 32'hFFFF_FF80, 0, 0, "R10 carry overflow");
      send(1, 1, 900, 32'h8000_0000, 0, 1, "R10 huge exponent");
      idle(3);

      // R12: inputs ignored while idle
      @(negedge clk);
      in_valid = 1'b0; in_class = 2'd3; in_mant = 32'hDEAD_BEEF; in_sign = 1'b1;
      in_exp = EW'(200);
      repeat (2) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || out_word !== last_word || out_flags !== last_flags) begin
         errors++;
         $display("FAIL R12: idle outputs %b %h %b, expected 0 %h %b",
                  out_valid, out_word, out_flags, last_word, last_flags);
      end

      // Random mix
      for (int i = 0; i < 400; i++) begin
         send(1'($urandom), (i % 9 == 0) ? 2'($urandom) : 2'd1,
              int'($urandom_range(310)) - 170,
              32'h8000_0000 | 32'($urandom), 1'($urandom), 2'($urandom),
              "R6 random");
      end
      idle(4);
      checks++;
      if (exp_w_q.size() != 0) begin
         errors++;
         $display("FAIL R1: %0d results missing, expected 0", exp_w_q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule